// File: doc/BRIEF.md
# Crystal Offset Pulse Compensator

This block trims the rate of a 32.768 kHz time base to correct a crystal that runs fast or slow. It takes the raw count enable of the oscillator domain and turns it into an effective enable stream. It divides that stream down to a one-cycle seconds tick for the time counter. Once per correction interval, the block changes the number of oscillator pulses it needs to complete that interval. It does this by swallowing raw enables, which slows the clock, or by inserting extra enables into idle cycles, which speeds it up.

Software writes one 8-bit setting. The setting holds a 6-bit code, a direction flag and an interval-length flag. The value is first held in a shadow register. It takes effect only at the next interval boundary, which is the last seconds tick of the running interval. A busy output stays high from the write until that boundary, so software knows when the next write is safe. The interval lengths and the enables per second are parameters. By default they are 20 s and 60 s, at 32768 enables per second.

Top module: `xtal_trim_comp`

## Requirements
- R1: After reset, sec_tick and cfg_busy are low, the stored setting is 0x00, and the first interval takes exactly SHORT_SEC×DIV_PER_SEC raw enables.
- R2: The setting byte has three fields. Bits 5:0 are the code, bit 6 selects removal (1) or addition (0), and bit 7 selects an interval of LONG_SEC seconds (1) or SHORT_SEC seconds (0). The correction applies once in every interval of the selected length.
- R3: A code of 0 applies no correction in either direction, so the interval takes exactly N×DIV_PER_SEC raw enables.
- R4: In addition mode, code v inserts 2×(v−1) enables, so the interval completes after N×DIV_PER_SEC − 2×(v−1) raw enables.
- R5: In removal mode, code v (v≠0) swallows 2×(((~v)&0x3F)+1) raw enables, so the interval takes N×DIV_PER_SEC + 2×(((~v)&0x3F)+1) raw enables.
- R6: cfg_busy is high in the cycle after a write. It stays high until the boundary that ends the running interval, and it is low after that boundary's sec_tick.
- R7: The interval running when a write occurs keeps its old setting. The next interval uses the last value written before the boundary.
- R8: Inserted enables occupy only cycles where raw_en is low. They start right after the boundary, so the first second of an addition interval holds fewer than DIV_PER_SEC raw enables but at least DIV_PER_SEC/2−1 when raw_en alternates.
- R9: sec_tick is a one-cycle pulse, raised after every DIV_PER_SEC effective enables. With no correction, each second therefore spans exactly DIV_PER_SEC raw enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_en | input | 1 | Raw oscillator count enable, one cycle per pulse |
| cfg_wr | input | 1 | Write strobe for the compensation setting |
| cfg_wdata | input | 8 | Setting: [7] long interval, [6] remove, [5:0] code |
| sec_tick | output | 1 | Corrected one-cycle seconds tick |
| cfg_busy | output | 1 | A written setting waits for the next interval boundary |

## Verification
The bench steps through all 64 codes in addition mode and all 64 in removal mode on the short interval, with raw_en alternating every cycle. It counts the raw enables between boundary ticks, and that count separates the one-offset addition code from the inverted removal code, and separates both from the zero code. A few long-interval settings show that bit 7 changes the interval length, not the step size. Two writes within one interval show that the last write wins and that the running interval is not affected. The first second of each addition interval shows that inserted enables come early and fall only in idle cycles.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int CODE_W  = 6;
  localparam int PULSE_W = 8;

  typedef struct packed {
    logic              long_iv;
    logic              remove;
    logic [CODE_W-1:0] code;
  } trim_cfg_t;

  // Number of raw pulses added or removed per interval for a setting.
  function automatic logic [PULSE_W-1:0] trim_pulse_count(input trim_cfg_t c);
    logic [CODE_W-1:0]  inv;
    logic [PULSE_W-1:0] steps;
    inv = ~c.code;
    if (c.code == '0)
      steps = '0;
    else if (c.remove)
      steps = PULSE_W'(inv) + PULSE_W'(1);
    else
      steps = PULSE_W'(c.code) - PULSE_W'(1);
    return steps << 1;
  endfunction
endpackage

// File: rtl/trim_cfg_reg.sv
module trim_cfg_reg
  import trim_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  trim_cfg_t wr_cfg,
  input  logic      boundary,
  output trim_cfg_t active,
  output trim_cfg_t next_active,
  output logic      busy
);
  trim_cfg_t shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      active <= '0;
      busy   <= 1'b0;
    end else begin
      if (boundary) begin
        if (busy) active <= shadow;
        busy <= 1'b0;
      end
      if (wr_en) begin
        shadow <= wr_cfg;
        busy   <= 1'b1;
      end
    end
  end

  assign next_active = (boundary && busy) ? shadow : active;

  // R6
  busy_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> busy);
  // R6
  busy_fall_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(boundary));
  // R7
  capture_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (active == $past(shadow)));
  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(busy) && !$past(wr_en)) |-> (active == $past(active)));
endmodule

// File: rtl/trim_pulse_gate.sv
module trim_pulse_gate
  import trim_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      raw_en,
  input  logic      boundary,
  input  trim_cfg_t load_cfg,
  output logic      eff_en
);
  logic [PULSE_W-1:0] pend;
  logic               rem_q;
  logic               swallow;
  logic               insert;

  always_comb begin
    swallow = rem_q && (pend != '0) && raw_en;
    insert  = !rem_q && (pend != '0) && !raw_en;
    eff_en  = (raw_en && !swallow) || insert;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      rem_q <= 1'b0;
    end else if (boundary) begin
      pend  <= trim_pulse_count(load_cfg);
      rem_q <= load_cfg.remove;
    end else if (swallow || insert) begin
      pend <= pend - PULSE_W'(1);
    end
  end

  // R4 R5: the budget only shrinks within an interval
  pend_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(boundary) |-> (pend <= $past(pend)));
  // R8: an enable with raw low means budget was spent
  insert_spends_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_en && !raw_en && !boundary) |=> (pend == $past(pend) - PULSE_W'(1)));
endmodule

// File: rtl/trim_sec_div.sv
module trim_sec_div #(
  parameter int DIV_PER_SEC = 32768,
  parameter int SHORT_SEC   = 20,
  parameter int LONG_SEC    = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic eff_en,
  input  logic long_iv,
  output logic boundary,
  output logic sec_tick
);
  localparam int SUB_W = (DIV_PER_SEC > 1) ? $clog2(DIV_PER_SEC) : 1;
  localparam int MAX_SEC = (LONG_SEC > SHORT_SEC) ? LONG_SEC : SHORT_SEC;
  localparam int SEC_W = (MAX_SEC > 1) ? $clog2(MAX_SEC) : 1;

  logic [SUB_W-1:0] sub_cnt;
  logic [SEC_W-1:0] sec_cnt;
  logic [SEC_W-1:0] last_sec;
  logic             sec_wrap;

  always_comb begin
    last_sec = long_iv ? SEC_W'(LONG_SEC - 1) : SEC_W'(SHORT_SEC - 1);
    sec_wrap = eff_en && (sub_cnt == SUB_W'(DIV_PER_SEC - 1));
    boundary = sec_wrap && (sec_cnt == last_sec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_cnt  <= '0;
      sec_cnt  <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= sec_wrap;
      if (eff_en) sub_cnt <= sec_wrap ? '0 : sub_cnt + SUB_W'(1);
      if (sec_wrap) sec_cnt <= (sec_cnt == last_sec) ? '0 : sec_cnt + SEC_W'(1);
    end
  end

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    sec_cnt <= SEC_W'(MAX_SEC - 1));
  // R9
  tick_from_enable_chk: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> $past(eff_en));

  generate
    if (DIV_PER_SEC > 1) begin : g_single
      // R9
      tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);
    end
  endgenerate
endmodule

// File: rtl/xtal_trim_comp.sv
module xtal_trim_comp
  import trim_pkg::*;
#(
  parameter int DIV_PER_SEC = 32768,
  parameter int SHORT_SEC   = 20,
  parameter int LONG_SEC    = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_en,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic       sec_tick,
  output logic       cfg_busy
);
  trim_cfg_t active_cfg;
  trim_cfg_t next_cfg;
  logic      boundary;
  logic      eff_en;

  trim_cfg_reg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_wr),
    .wr_cfg     (trim_cfg_t'(cfg_wdata)),
    .boundary   (boundary),
    .active     (active_cfg),
    .next_active(next_cfg),
    .busy       (cfg_busy)
  );

  trim_pulse_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .raw_en  (raw_en),
    .boundary(boundary),
    .load_cfg(next_cfg),
    .eff_en  (eff_en)
  );

  trim_sec_div #(
    .DIV_PER_SEC(DIV_PER_SEC),
    .SHORT_SEC  (SHORT_SEC),
    .LONG_SEC   (LONG_SEC)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .eff_en  (eff_en),
    .long_iv (active_cfg.long_iv),
    .boundary(boundary),
    .sec_tick(sec_tick)
  );
endmodule

// File: tb/test_xtal_trim_comp.sv
module test_xtal_trim_comp;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 32;
  localparam int SHORT = 8;
  localparam int LONG  = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       sec_tick;
  logic       cfg_busy;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  wd_hit = 1'b0;
  bit  phase = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xtal_trim_comp #(.DIV_PER_SEC(DIV), .SHORT_SEC(SHORT), .LONG_SEC(LONG)) i_xtal_trim_comp (
    .clk(clk), .rst(rst), .raw_en(raw_en), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .sec_tick(sec_tick), .cfg_busy(cfg_busy)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int iv_sec(input logic [7:0] c);
    return c[7] ? LONG : SHORT;
  endfunction

  function automatic int pulses(input logic [7:0] c);
    int v;
    v = int'(c[5:0]);
    if (v == 0) return 0;
    if (c[6]) return 2 * (((~v) & 63) + 1);
    return 2 * (v - 1);
  endfunction

  function automatic int exp_raw(input logic [7:0] c);
    int base;
    base = iv_sec(c) * DIV;
    return c[6] ? base + pulses(c) : base - pulses(c);
  endfunction

  function automatic string raw_tag(input logic [7:0] c);
    if (c[7]) return "R2";
    if (c[5:0] == 6'd0) return "R3";
    return c[6] ? "R5" : "R4";
  endfunction

  function automatic logic [7:0] cfg_at(input int idx);
    if (idx < 128) return {1'b0, idx[6], idx[5:0]};
    if (idx == 128) return 8'h80;
    if (idx == 129) return 8'h85;
    return 8'hE8;
  endfunction

  // Runs one interval under setting cur, optionally writing w1/w2 during it.
  task automatic run_iv(input logic [7:0] cur, input bit do1, input logic [7:0] d1,
                        input bit do2, input logic [7:0] d2);
    int  raw_n = 0, sec_n = 0, per_sec = 0, first_sec = -1, cyc = 0;
    bit  bad_sec = 0, busy_lo = 0, prev_tick = 0, dbl = 0;
    int  nsec = iv_sec(cur);
    while (sec_n < nsec && !wd_hit) begin
      raw_en = phase;
      phase  = !phase;
      cfg_wr = (do1 && cyc == 0) || (do2 && cyc == 20);
      cfg_wdata = (cyc == 20) ? d2 : d1;
      @(posedge clk); #1;
      cfg_wr = 1'b0;
      if (raw_en) begin raw_n++; per_sec++; end
      if (sec_tick) begin
        if (prev_tick) dbl = 1;
        sec_n++;
        if (first_sec < 0) first_sec = per_sec;
        if (per_sec != DIV) bad_sec = 1;
        per_sec = 0;
      end
      prev_tick = sec_tick;
      if (do1 && sec_n < nsec && cfg_busy !== 1'b1) busy_lo = 1;
      cyc++;
    end
    check(raw_n == exp_raw(cur), raw_tag(cur), raw_n, exp_raw(cur));
    check(!dbl, "R9", int'(dbl), 0);
    if (pulses(cur) == 0)
      check(!bad_sec, "R9", int'(bad_sec), 0);
    if (!cur[6] && pulses(cur) > 0)
      check(first_sec < DIV && first_sec >= DIV/2 - 1, "R8", first_sec, DIV - 1);
    if (do1) check(!busy_lo, "R6", int'(busy_lo), 0);
    check(cfg_busy === 1'b0, "R6", int'(cfg_busy), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    wd_hit = 1'b1;
  end

  initial begin
    logic [7:0] prev;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check(sec_tick === 1'b0, "R1", int'(sec_tick), 0);
    check(cfg_busy === 1'b0, "R1", int'(cfg_busy), 0);
    rst = 1'b0;
    prev = 8'h00;
    // R1: first interval uses the reset setting; R7: pipelined writes
    for (int i = 0; i < 131; i++) begin
      run_iv(prev, 1'b1, cfg_at(i), 1'b0, 8'h00);
      prev = cfg_at(i);
    end
    // R7: two writes in one interval, the second one wins
    run_iv(prev, 1'b1, 8'h10, 1'b1, 8'h5A);
    prev = 8'h5A;
    run_iv(prev, 1'b0, 8'h00, 1'b0, 8'h00);
    check(cfg_busy === 1'b0, "R7", int'(cfg_busy), 0);
    if (wd_hit) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule